// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one block transfer instruction. A 16-bit register mask names which of sixteen registers take part. The block moves those registers to memory or from memory, one register per clock cycle. The registers go to or come from consecutive word addresses, and a base register value sets where that range starts. Four mode bits choose the operation:

- load or store,
- adjust the address before or after each access,
- walk up or down,
- write the adjusted base back to the base register.

A fifth bit marks the request as privileged.

A controller pulses `start` with the mode bits, the mask, the base register index and the current base value. The block then drives a single-word memory port, plus a register file port that has one read and one write. The register file port serves store data, load data and the base writeback. When the operation ends, `done` pulses for one cycle. `fault` pulses with it if a privileged request arrived while the processor was not in supervisor mode. A faulted request moves nothing.

The control is a four-state machine:

- **IDLE**: waits for `start`. It goes to DONE straight away when the request is denied or the mask is empty. Otherwise it goes to XFER.
- **XFER**: moves the lowest-numbered register still pending. After the last one, it goes to WBACK when writeback is in effect, or to DONE when it is not.
- **WBACK**: writes the final base into the base register and goes to DONE.
- **DONE**: pulses `done` and returns to IDLE.

Top module: `lsm_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `mem_req` and `rf_we` are all low. While `busy` is low, `mem_req` and `rf_we` stay low.
- R2: Each XFER cycle moves exactly one register, in ascending register number. Successive transfers use word addresses that rise by 4 each cycle, so the lowest-numbered register always gets the lowest address, in both directions.
- R3: With n set mask bits and base B, the first address depends on the mode (`op_up`=1 means increment, `op_pre`=1 means adjust before access):
  - up, after: B
  - up, before: B+4
  - down, after: B-4n+4
  - down, before: B-4n
- R4: With `op_load`=1, each transfer writes `mem_rdata` into the register file at the listed index. With `op_load`=0, each transfer writes the register's value to memory (`mem_we`=1), and the register file is never written during a store transfer.
- R5: With `op_wb`=1, one extra cycle after the last transfer writes B+4n (up) or B-4n (down) into register `base_idx`.
- R6: In a load whose mask includes `base_idx`, the loaded word stays in the base register and no writeback cycle takes place, even with `op_wb`=1.
- R7: In a store whose mask includes `base_idx`, the value stored for that register is the original base value B.
- R8: An empty mask causes `done` one cycle after `start`, with `fault` low, and no memory or register write, even with `op_wb`=1.
- R9: With `op_priv`=1 and `supervisor`=0, the block raises `done` and `fault` together one cycle after `start` and makes no memory or register write. With `supervisor`=1, the same request runs normally.
- R10: `done` is a one-cycle pulse. Counting cycles from the `start` edge, it arrives at n+1 without writeback and at n+2 with writeback.
- R11: A `start` that arrives while `busy` is high is ignored and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| op_load | input | 1 | 1 = load registers from memory, 0 = store |
| op_pre | input | 1 | 1 = adjust address before each access |
| op_up | input | 1 | 1 = increment, 0 = decrement |
| op_wb | input | 1 | 1 = write the final base back |
| op_priv | input | 1 | Request needs supervisor mode |
| supervisor | input | 1 | Processor is in supervisor mode |
| reg_list | input | NREG | Register selection mask, bit i = register i |
| base_idx | input | log2(NREG) | Index of the base register |
| base_val | input | XLEN | Current value of the base register |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Load data, same cycle |
| rf_raddr | output | log2(NREG) | Register file read index |
| rf_rdata | input | XLEN | Register file read data, same cycle |
| rf_we | output | 1 | Register file write |
| rf_waddr | output | log2(NREG) | Register file write index |
| rf_wdata | output | XLEN | Register file write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete pulse |
| fault | output | 1 | Privilege fault, with done |

## Verification
A load and the base writeback both compete for the single register file write port. When the base register appears in a load's mask, the last transfers and the writeback would target the same register in neighbouring cycles. Directed loads with the base in the mask and `op_wb` set provoke this case, and random masks hit it again. The result is judged by the base register's final value, which must equal the loaded memory word, and by the latency, which must drop to n+1.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } lsm_state_t;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0]             bits,
    output logic [$clog2(N+1)-1:0]   count
);
    localparam int unsigned CW = $clog2(N+1);

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0]           mask,
    output logic [$clog2(N)-1:0]   idx,
    output logic [N-1:0]           rest,
    output logic                   last
);
    localparam int unsigned IW = $clog2(N);

    logic [N-1:0] sel;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_sel
            if (g == 0) begin : g_first
                assign sel[g] = mask[g];
            end else begin : g_other
                assign sel[g] = mask[g] & ~(|mask[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) idx = IW'(i);
        end
    end

    assign rest = mask & ~sel;
    assign last = (rest == '0);
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan #(
    parameter int unsigned NREG       = 16,
    parameter int unsigned XLEN       = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [XLEN-1:0]            base,
    input  logic [$clog2(NREG+1)-1:0]  count,
    input  logic                       pre,
    input  logic                       up,
    output logic [XLEN-1:0]            first_addr,
    output logic [XLEN-1:0]            final_base
);
    localparam int unsigned SH = $clog2(WORD_BYTES);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] span;
    logic [XLEN-1:0] low_end;

    assign span    = XLEN'(count) << SH;
    assign low_end = base - span;

    always_comb begin
        if (up) begin
            first_addr = pre ? (base + STEP) : base;
            final_base = base + span;
        end else begin
            first_addr = pre ? low_end : (low_end + STEP);
            final_base = low_end;
        end
    end
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
    import lsm_pkg::*;
#(
    parameter int unsigned NREG       = 16,
    parameter int unsigned XLEN       = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      op_load,
    input  logic                      op_pre,
    input  logic                      op_up,
    input  logic                      op_wb,
    input  logic                      op_priv,
    input  logic                      supervisor,
    input  logic [NREG-1:0]           reg_list,
    input  logic [$clog2(NREG)-1:0]   base_idx,
    input  logic [XLEN-1:0]           base_val,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [XLEN-1:0]           mem_addr,
    output logic [XLEN-1:0]           mem_wdata,
    input  logic [XLEN-1:0]           mem_rdata,
    output logic [$clog2(NREG)-1:0]   rf_raddr,
    input  logic [XLEN-1:0]           rf_rdata,
    output logic                      rf_we,
    output logic [$clog2(NREG)-1:0]   rf_waddr,
    output logic [XLEN-1:0]           rf_wdata,
    output logic                      busy,
    output logic                      done,
    output logic                      fault
);
    localparam int unsigned IW = $clog2(NREG);
    localparam int unsigned CW = $clog2(NREG+1);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    lsm_state_t state_q, state_d;

    logic [NREG-1:0] mask_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] final_q;
    logic [IW-1:0]   bidx_q;
    logic            load_q;
    logic            wb_q;
    logic            fault_q;

    logic [CW-1:0]   n_sel;
    logic [XLEN-1:0] first_addr;
    logic [XLEN-1:0] final_base;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] mask_rest;
    logic            last_xfer;
    logic            deny;
    logic            list_empty;
    logic            wb_eff;

    lsm_popcount #(.N(NREG)) u_count (
        .bits  (reg_list),
        .count (n_sel)
    );

    lsm_addr_plan #(.NREG(NREG), .XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base       (base_val),
        .count      (n_sel),
        .pre        (op_pre),
        .up         (op_up),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    lsm_lowbit #(.N(NREG)) u_pick (
        .mask (mask_q),
        .idx  (cur_idx),
        .rest (mask_rest),
        .last (last_xfer)
    );

    assign deny       = op_priv & ~supervisor;
    assign list_empty = (reg_list == '0);
    assign wb_eff     = op_wb & ~(op_load & reg_list[base_idx]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (deny || list_empty) ? ST_DONE : ST_XFER;
            ST_XFER:  if (last_xfer) state_d = wb_q ? ST_WBACK : ST_DONE;
            ST_WBACK: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            addr_q  <= '0;
            final_q <= '0;
            bidx_q  <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q  <= reg_list;
                        addr_q  <= first_addr;
                        final_q <= final_base;
                        bidx_q  <= base_idx;
                        load_q  <= op_load;
                        wb_q    <= wb_eff;
                        fault_q <= deny;
                    end
                end
                ST_XFER: begin
                    mask_q <= mask_rest;
                    addr_q <= addr_q + STEP;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rf_raddr  = '0;
        rf_we     = 1'b0;
        rf_waddr  = '0;
        rf_wdata  = '0;
        busy      = 1'b1;
        done      = 1'b0;
        fault     = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_XFER: begin
                mem_req   = 1'b1;
                mem_we    = ~load_q;
                mem_addr  = addr_q;
                rf_raddr  = cur_idx;
                mem_wdata = load_q ? '0 : rf_rdata;
                rf_we     = load_q;
                rf_waddr  = cur_idx;
                rf_wdata  = load_q ? mem_rdata : '0;
            end
            ST_WBACK: begin
                rf_we    = 1'b1;
                rf_waddr = bidx_q;
                rf_wdata = final_q;
            end
            ST_DONE: begin
                done  = 1'b1;
                fault = fault_q;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsm_sequencer_chk.sv
module lsm_sequencer_chk #(
    parameter int unsigned NREG = 16,
    parameter int unsigned XLEN = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    op_priv,
    input logic                    supervisor,
    input logic [NREG-1:0]         reg_list,
    input logic                    busy,
    input logic                    done,
    input logic                    fault,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [XLEN-1:0]         mem_addr,
    input logic                    rf_we
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + XLEN'(4)));

    assert_store_no_rf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);

    assert_empty_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && reg_list == '0 && !(op_priv && !supervisor)) |=> (done && !fault && !mem_req));

    assert_priv_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_priv && !supervisor) |=> (done && fault && !mem_req && !rf_we));

    assert_fault_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind lsm_sequencer lsm_sequencer_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_priv    (op_priv),
    .supervisor (supervisor),
    .reg_list   (reg_list),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .rf_we      (rf_we)
);

// File: tb/lsm_sequencer_test.sv
module lsm_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_load = 1'b0, op_pre = 1'b0, op_up = 1'b0, op_wb = 1'b0;
    logic        op_priv = 1'b0, supervisor = 1'b0;
    logic [15:0] reg_list = '0;
    logic [3:0]  base_idx = '0;
    logic [31:0] base_val = '0;
    logic        mem_req, mem_we, rf_we, busy, done, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [3:0]  rf_raddr, rf_waddr;

    logic [31:0] mem  [64];
    logic [31:0] regs [16];
    logic [31:0] exp_mem [64];
    logic [31:0] exp_reg [16];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lsm_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_load(op_load), .op_pre(op_pre),
        .op_up(op_up), .op_wb(op_wb), .op_priv(op_priv), .supervisor(supervisor),
        .reg_list(reg_list), .base_idx(base_idx), .base_val(base_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .busy(busy), .done(done), .fault(fault)
    );

    assign mem_rdata = mem[mem_addr[7:2]];
    assign rf_rdata  = regs[rf_raddr];

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (rf_we) regs[rf_waddr] <= rf_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int popc(input logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic [31:0] first_of(input logic pre, input logic up, input logic [31:0] b, input int n);
        if (up) return pre ? b + 32'd4 : b;
        return pre ? b - 32'(4*n) : b - 32'(4*n) + 32'd4;
    endfunction

    task automatic run_op(input logic ld, input logic pr, input logic upd, input logic wb,
                          input logic pv, input logic sup, input logic [15:0] list,
                          input logic [3:0] bidx, input bit poke);
        int n, k, cyc, exp_lat, j;
        logic [31:0] b, fa, a;
        logic denied, wbe;
        logic [3:0] exp_idx;
        b = 32'h80 + 32'(4 * ($urandom % 16));
        regs[bidx] = b;
        n = popc(list);
        denied = pv && !sup;
        wbe = wb && !(ld && list[bidx]);
        fa = first_of(pr, upd, b, n);
        for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
        for (int i = 0; i < 16; i++) exp_reg[i] = regs[i];
        if (!denied && n != 0) begin
            k = 0;
            for (int i = 0; i < 16; i++) begin
                if (list[i]) begin
                    a = fa + 32'(4*k);
                    if (ld) exp_reg[i] = mem[a[7:2]];
                    else    exp_mem[a[7:2]] = regs[i];
                    k++;
                end
            end
            if (wbe) exp_reg[bidx] = upd ? b + 32'(4*n) : b - 32'(4*n);
            exp_lat = n + 1 + (wbe ? 1 : 0);
        end else begin
            exp_lat = 1;
        end
        @(negedge clk);
        op_load = ld; op_pre = pr; op_up = upd; op_wb = wb; op_priv = pv; supervisor = sup;
        reg_list = list; base_idx = bidx; base_val = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1; k = 0;
        while (!done && cyc < 40) begin
            if (poke && cyc == 1) begin
                start = 1'b1; reg_list = ~list; base_val = 32'h0; op_load = ~ld;
            end else begin
                start = 1'b0;
            end
            if (mem_req) begin
                exp_idx = 4'd0;
                j = 0;
                for (int i = 15; i >= 0; i--) begin
                    if (list[i]) begin
                        if (popc(list & 16'((32'd1 << i) - 1)) == k) exp_idx = 4'(i);
                    end
                end
                a = fa + 32'(4*k);
                check(mem_addr == a, "R3/R2 transfer address", mem_addr, a);
                check((ld ? rf_waddr : rf_raddr) == exp_idx, "R2 register order", 32'(ld ? rf_waddr : rf_raddr), 32'(exp_idx));
                check(mem_we == !ld && (ld || !rf_we), "R4 direction", {30'd0, mem_we, rf_we}, {30'd0, !ld, 1'b0});
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == exp_lat, "R10 done latency", 32'(cyc), 32'(exp_lat));
        check(done && fault == denied, "R9 fault flag", {30'd0, done, fault}, {30'd0, 1'b1, denied});
        check(k == (denied ? 0 : n), "R8/R9 transfer count", 32'(k), 32'(denied ? 0 : n));
        @(negedge clk);
        check(!done, "R10 done single pulse", {31'd0, done}, 32'd0);
        for (int i = 0; i < 16; i++)
            check(regs[i] == exp_reg[i], "R4/R5/R6 register file", regs[i], exp_reg[i]);
        for (int i = 0; i < 64; i++)
            if (mem[i] !== exp_mem[i]) check(1'b0, "R4/R7 memory", mem[i], exp_mem[i]);
        checks++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mem[i] = $urandom;
        for (int i = 0; i < 16; i++) regs[i] = $urandom;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fault && !mem_req && !rf_we, "R1 reset state",
              {27'd0, busy, done, fault, mem_req, rf_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req && !rf_we, "R1 idle after reset", {29'd0, busy, mem_req, rf_we}, 32'd0);

        // R3: each addressing mode, store then load
        run_op(0, 0, 1, 0, 0, 0, 16'h00F1, 4'd13, 0);
        run_op(0, 1, 1, 1, 0, 0, 16'h0A0A, 4'd13, 0);
        run_op(1, 0, 0, 1, 0, 0, 16'h3003, 4'd13, 0);
        run_op(1, 1, 0, 0, 0, 0, 16'h8001, 4'd13, 0);
        // R6: load with base in list and writeback
        run_op(1, 0, 1, 1, 0, 0, 16'h0031, 4'd4, 0);
        // R7: store with base in list and writeback, decrement before
        run_op(0, 1, 0, 1, 0, 0, 16'h0111, 4'd8, 0);
        // R8: empty list with writeback requested
        run_op(0, 0, 1, 1, 0, 0, 16'h0000, 4'd2, 0);
        // R9: denied and permitted privileged requests
        run_op(0, 0, 1, 1, 1, 0, 16'hFFFF, 4'd13, 0);
        run_op(1, 0, 1, 1, 1, 1, 16'h00C0, 4'd13, 0);
        // R2: full list, R5 writeback down
        run_op(0, 0, 0, 1, 0, 0, 16'hFFFF, 4'd3, 0);
        // R11: start pulsed while busy
        run_op(0, 0, 1, 0, 0, 0, 16'h0F00, 4'd1, 1);
        for (int t = 0; t < 40; t++) begin
            run_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 4) == 0, 1'($urandom), 16'($urandom) & 16'($urandom | 32'h5),
                   4'($urandom), ($urandom % 8) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule